// File: doc/BRIEF.md
# Memory Bank Enable Controller with DMA Override

This block decides which halves of a two-half memory board respond to bus cycles. It holds one enable bit for the upper half and one for the lower half. A host output write to a chosen I/O port address reloads both bits at once. Each bit looks at the data bus through its own 8-bit mask. The bit becomes enabled when any data line picked by its mask is high, and disabled when none is. Because of this, one port write can switch the two halves independently, or together, depending on how the masks are set.

DMA cycles can bypass the stored state. A static override switch sets whether they do. With the override on, and while the DMA-cycle input is high, each half takes a fixed enable value from its own static setting instead of the stored bit. With the override off, DMA and host cycles behave the same, and the stored bits drive the enables. The enables seen at the outputs are combinational from the stored bits and the override inputs. The stored bits change on the clock edge that follows a recognised write.

Top module: `bank_enable_ctrl`

## Requirements
- R1: After a synchronous reset both stored bits are 1. With the override off, `hi_enable` and `lo_enable` are then both 1.
- R2: A port write is recognised in a clock cycle only when all three of these hold in that cycle: `io_addr` equals `cfg_port_addr`, `io_out_cycle` is 1, and `io_wr_n` is 0. In any other cycle the stored bits keep their values, whatever `io_data` carries.
- R3: On a recognised write, the upper stored bit loads 1 if `io_data & cfg_mask_hi` is nonzero and 0 otherwise. The new value is visible from the next rising clock edge.
- R4: On a recognised write, the lower stored bit loads 1 if `io_data & cfg_mask_lo` is nonzero and 0 otherwise. The new value is visible from the next rising clock edge.
- R5: The two stored bits are loaded independently. A mask of all zeros always loads 0, and the same write may load different values into the two halves.
- R6: When `cfg_dma_ovr_en` is 0, `dma_cycle` has no effect. Each output equals its stored bit.
- R7: When `cfg_dma_ovr_en` is 1 and `dma_cycle` is 1, `hi_enable` equals `cfg_dma_hi_en`, whatever the upper stored bit holds.
- R8: When `cfg_dma_ovr_en` is 1 and `dma_cycle` is 1, `lo_enable` equals `cfg_dma_lo_en`, whatever the lower stored bit holds.
- R9: When `cfg_dma_ovr_en` is 1 and `dma_cycle` is 0, each output equals its stored bit. The stored bits are never changed by the override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O port address of the current cycle |
| io_out_cycle | input | 1 | High when the current cycle is an output (I/O write) cycle |
| io_wr_n | input | 1 | Active-low write strobe |
| io_data | input | DATA_W | Data bus |
| cfg_port_addr | input | ADDR_W | Port address that selects the bank register |
| cfg_mask_hi | input | DATA_W | Data lines that feed the upper-half bit |
| cfg_mask_lo | input | DATA_W | Data lines that feed the lower-half bit |
| cfg_dma_ovr_en | input | 1 | DMA override switch |
| cfg_dma_hi_en | input | 1 | Upper-half enable used while overriding |
| cfg_dma_lo_en | input | 1 | Lower-half enable used while overriding |
| dma_cycle | input | 1 | High while a DMA cycle is in progress |
| hi_enable | output | 1 | Effective upper-half enable |
| lo_enable | output | 1 | Effective lower-half enable |

## Verification
Every cycle, the assertions check three things. A stored bit stays put without a recognised write. A recognised write loads the masked OR of the data bus. The outputs follow either the fixed DMA values or the stored bits, according to the override and DMA inputs. Only the bench scenarios show the rest: the reset value of both halves, the rejection of near-miss writes (one of the three conditions missing), and that a write and a later override leave the other half untouched. They also show the end-to-end sequence of a write followed by a DMA cycle and then a return to host cycles.

// File: rtl/bank_sel_pkg.sv
package bank_sel_pkg;

    // index of each half inside packed pair vectors
    localparam int HALF_LO   = 0;
    localparam int HALF_HI   = 1;
    localparam int NUM_HALVES = 2;

    typedef struct packed {
        logic hi;
        logic lo;
    } half_pair_t;

    typedef struct packed {
        logic       ovr_en;
        half_pair_t forced;
    } dma_cfg_t;

    // pick between stored and forced pair
    function automatic half_pair_t choose_pair(input half_pair_t stored,
                                               input half_pair_t forced,
                                               input logic       use_forced);
        return use_forced ? forced : stored;
    endfunction

    localparam half_pair_t RESET_PAIR = '{hi: 1'b1, lo: 1'b1};

endpackage

// File: rtl/bsr_port_decode.sv
module bsr_port_decode #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] port,
    input  logic              out_cycle,
    input  logic              wr_n,
    output logic              wr_pulse
);
    logic addr_hit;

    always_comb begin
        addr_hit = (addr == port);
        wr_pulse = addr_hit && out_cycle && !wr_n;
    end
endmodule

// File: rtl/bsr_bank_latch.sv
module bsr_bank_latch #(
    parameter int   DATA_W    = 8,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] mask,
    output logic              bit_q
);
    logic [DATA_W-1:0] routed;
    logic              any_high;

    always_comb begin
        routed   = data & mask;
        any_high = |routed;
    end

    always_ff @(posedge clk) begin
        if (rst)
            bit_q <= RESET_VAL;
        else if (wr)
            bit_q <= any_high;
    end

    // R2
    hold_without_write_chk: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(bit_q));

    // R3 R4
    load_masked_or_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (bit_q == ($past(data & mask) != '0)));
endmodule

// File: rtl/bsr_dma_mux.sv
module bsr_dma_mux
    import bank_sel_pkg::*;
(
    input  half_pair_t stored,
    input  dma_cfg_t   cfg,
    input  logic       dma_cycle,
    output half_pair_t eff
);
    logic take_forced;

    always_comb begin
        take_forced = cfg.ovr_en && dma_cycle;
        eff         = choose_pair(stored, cfg.forced, take_forced);
    end
endmodule

// File: rtl/bank_enable_ctrl.sv
module bank_enable_ctrl
    import bank_sel_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_out_cycle,
    input  logic              io_wr_n,
    input  logic [DATA_W-1:0] io_data,
    input  logic [ADDR_W-1:0] cfg_port_addr,
    input  logic [DATA_W-1:0] cfg_mask_hi,
    input  logic [DATA_W-1:0] cfg_mask_lo,
    input  logic              cfg_dma_ovr_en,
    input  logic              cfg_dma_hi_en,
    input  logic              cfg_dma_lo_en,
    input  logic              dma_cycle,
    output logic              hi_enable,
    output logic              lo_enable
);
    logic                             wr_pulse;
    logic [NUM_HALVES-1:0][DATA_W-1:0] mask_arr;
    logic [NUM_HALVES-1:0]             bits_q;
    half_pair_t                        stored;
    half_pair_t                        eff;
    dma_cfg_t                          dcfg;

    always_comb begin
        mask_arr[HALF_HI] = cfg_mask_hi;
        mask_arr[HALF_LO] = cfg_mask_lo;
        stored.hi         = bits_q[HALF_HI];
        stored.lo         = bits_q[HALF_LO];
        dcfg.ovr_en       = cfg_dma_ovr_en;
        dcfg.forced.hi    = cfg_dma_hi_en;
        dcfg.forced.lo    = cfg_dma_lo_en;
        hi_enable         = eff.hi;
        lo_enable         = eff.lo;
    end

    bsr_port_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr      (io_addr),
        .port      (cfg_port_addr),
        .out_cycle (io_out_cycle),
        .wr_n      (io_wr_n),
        .wr_pulse  (wr_pulse)
    );

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        localparam logic RV = (h == HALF_HI) ? RESET_PAIR.hi : RESET_PAIR.lo;
        bsr_bank_latch #(.DATA_W(DATA_W), .RESET_VAL(RV)) u_latch (
            .clk   (clk),
            .rst   (rst),
            .wr    (wr_pulse),
            .data  (io_data),
            .mask  (mask_arr[h]),
            .bit_q (bits_q[h])
        );
    end

    bsr_dma_mux u_mux (
        .stored    (stored),
        .cfg       (dcfg),
        .dma_cycle (dma_cycle),
        .eff       (eff)
    );

    // R6
    ovr_off_follows_store_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_dma_ovr_en |-> (hi_enable == bits_q[HALF_HI] && lo_enable == bits_q[HALF_LO]));

    // R7
    dma_forces_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_dma_ovr_en && dma_cycle) |-> (hi_enable == cfg_dma_hi_en));

    // R8
    dma_forces_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_dma_ovr_en && dma_cycle) |-> (lo_enable == cfg_dma_lo_en));

    // R9
    ovr_idle_follows_store_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_dma_ovr_en && !dma_cycle) |-> (hi_enable == bits_q[HALF_HI] && lo_enable == bits_q[HALF_LO]));
endmodule

// File: tb/sim_bank_enable_ctrl.sv
module sim_bank_enable_ctrl;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int WATCHDOG = 5000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] io_addr = '0;
    logic          io_out_cycle = 1'b0;
    logic          io_wr_n = 1'b1;
    logic [DW-1:0] io_data = '0;
    logic [AW-1:0] cfg_port_addr = 8'h40;
    logic [DW-1:0] cfg_mask_hi = 8'hF0;
    logic [DW-1:0] cfg_mask_lo = 8'h0F;
    logic          cfg_dma_ovr_en = 1'b0;
    logic          cfg_dma_hi_en = 1'b0;
    logic          cfg_dma_lo_en = 1'b0;
    logic          dma_cycle = 1'b0;
    logic          hi_enable, lo_enable;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic model_hi = 1'b1;
    logic model_lo = 1'b1;

    typedef struct {
        logic  hi;
        logic  lo;
        string req;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    bank_enable_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_out_cycle(io_out_cycle),
        .io_wr_n(io_wr_n), .io_data(io_data), .cfg_port_addr(cfg_port_addr),
        .cfg_mask_hi(cfg_mask_hi), .cfg_mask_lo(cfg_mask_lo),
        .cfg_dma_ovr_en(cfg_dma_ovr_en), .cfg_dma_hi_en(cfg_dma_hi_en),
        .cfg_dma_lo_en(cfg_dma_lo_en), .dma_cycle(dma_cycle),
        .hi_enable(hi_enable), .lo_enable(lo_enable)
    );

    // driver: apply one cycle of stimulus at the falling edge, predict result
    task automatic drive(input logic [AW-1:0] a, input logic oc, input logic wn,
                         input logic [DW-1:0] d, input logic dma, input string req);
        exp_t e;
        @(negedge clk);
        io_addr = a; io_out_cycle = oc; io_wr_n = wn; io_data = d; dma_cycle = dma;
        if (a == cfg_port_addr && oc && !wn) begin
            model_hi = (d & cfg_mask_hi) != 0;
            model_lo = (d & cfg_mask_lo) != 0;
        end
        e.hi  = (cfg_dma_ovr_en && dma) ? cfg_dma_hi_en : model_hi;
        e.lo  = (cfg_dma_ovr_en && dma) ? cfg_dma_lo_en : model_lo;
        e.req = req;
        sb.push_back(e);
    endtask

    task automatic idle(input logic dma, input string req);
        drive(8'h00, 1'b0, 1'b1, 8'h00, dma, req);
    endtask

    task automatic wr(input logic [DW-1:0] d, input string req);
        drive(cfg_port_addr, 1'b1, 1'b0, d, 1'b0, req);
    endtask

    // monitor: compare shortly after each rising edge
    always @(posedge clk) begin
        #2;
        if (!rst && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (hi_enable !== e.hi || lo_enable !== e.lo) begin
                n_fail++;
                $display("FAIL %s: hi/lo actual %b%b expected %b%b", e.req,
                         hi_enable, lo_enable, e.hi, e.lo);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        idle(1'b0, "R1");
        idle(1'b1, "R1");
        // R3 R4 upper only
        wr(8'h10, "R3");
        idle(1'b0, "R3");
        // R4 lower only
        wr(8'h01, "R4");
        // R5 both halves, then none
        wr(8'h81, "R5");
        wr(8'h00, "R5");
        // R2 near-miss writes leave state at 00
        drive(8'h41, 1'b1, 1'b0, 8'hFF, 1'b0, "R2");
        drive(8'h40, 1'b0, 1'b0, 8'hFF, 1'b0, "R2");
        drive(8'h40, 1'b1, 1'b1, 8'hFF, 1'b0, "R2");
        idle(1'b0, "R2");
        // R5 zero mask always loads 0
        @(negedge clk); cfg_mask_lo = 8'h00;
        wr(8'hFF, "R5");
        @(negedge clk); cfg_mask_lo = 8'h0F;
        wr(8'h02, "R4");
        // R6 override off, dma has no effect (state hi=0 lo=1)
        @(negedge clk); cfg_dma_hi_en = 1'b1; cfg_dma_lo_en = 1'b0;
        idle(1'b1, "R6");
        idle(1'b0, "R6");
        // R7 R8 override on during dma
        @(negedge clk); cfg_dma_ovr_en = 1'b1;
        idle(1'b1, "R7");
        idle(1'b1, "R8");
        @(negedge clk); cfg_dma_hi_en = 1'b0; cfg_dma_lo_en = 1'b1;
        idle(1'b1, "R7");
        // R9 override on, not dma: stored bits
        idle(1'b0, "R9");
        // R9 write while overridden then dma drops
        drive(cfg_port_addr, 1'b1, 1'b0, 8'h20, 1'b1, "R8");
        idle(1'b0, "R9");
        @(negedge clk); cfg_dma_hi_en = 1'b1; cfg_dma_lo_en = 1'b1;
        idle(1'b1, "R7");
        idle(1'b0, "R9");
        // R1 reset again restores both
        @(negedge clk); cfg_dma_ovr_en = 1'b0; rst = 1'b1;
        @(negedge clk);
        while (sb.size() > 0) void'(sb.pop_front());
        model_hi = 1'b1; model_lo = 1'b1;
        rst = 1'b0;
        idle(1'b0, "R1");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule